// File: doc/BRIEF.md
# Endian-Configurable Load/Store Data Aligner

This block steers data between a 32-bit register file and a byte-addressable memory whose words are 32 bits wide. On the store side it takes a register value, an access size, the two low address bits and a run-time endian select. From these it forms the memory write word and a per-byte write-enable vector. Both store outputs are combinational, so they can feed a memory write port in the same cycle.

On the load side it takes the memory read word with the same size, offset and endian controls, plus a signed/unsigned flag. It picks out the addressed bytes in the order the endian mode requires. It then widens them to a full 32-bit register value, filling the upper bits with zeros or with copies of the item's top bit. The load result is registered and is qualified by a valid output one cycle after the read-data strobe.

Only naturally aligned accesses are supported. A halfword must sit at an even offset and a word at offset 0. Any other request, or the reserved size code, is flagged as misaligned and writes nothing.

Top module: `endian_aligner`

## Requirements
- R1: Size code 2'b00 is a byte access. A byte store puts `st_data[7:0]` on memory lane `st_ofs` in either endian mode and sets only that byte enable. Lane k is `st_wdata[8k+7:8k]` and holds the byte at address word_base+k.
- R2: Size code 2'b01 is a halfword. In little-endian mode (`endian_big`=0), a halfword store at offset o puts `st_data[7:0]` on lane o and `st_data[15:8]` on lane o+1. It enables exactly those two lanes.
- R3: In big-endian mode (`endian_big`=1), a halfword store at offset o puts `st_data[15:8]` on lane o and `st_data[7:0]` on lane o+1.
- R4: Size code 2'b10 is a word and enables all four lanes. In little-endian mode, register byte i goes to lane i. In big-endian mode, register byte 3-i goes to lane i. For example, 0x04050607 gives lanes 0..3 = 07,06,05,04 in little-endian mode and 04,05,06,07 in big-endian mode.
- R5: Lanes whose byte enable is low carry zero in `st_wdata`.
- R6: In little-endian mode, a load of n bytes at offset o takes its low-order byte from lane o and its high-order byte from lane o+n-1. With bytes AA,BB,CC,DD in lanes 0..3, the results are 0x000000AA, 0x0000BBAA and 0xDDCCBBAA for the three sizes.
- R7: In big-endian mode, a load takes its high-order byte from lane o. With the same memory contents the results are 0x000000AA, 0x0000AABB and 0xAABBCCDD.
- R8: An unsigned load (`ld_signed`=0) fills every result bit above the item with zero.
- R9: A signed load (`ld_signed`=1) fills every result bit above the item with the item's most significant bit.
- R10: `ld_valid` is high exactly in the cycle after a cycle with `ld_rvalid` high. `ld_result` and `ld_misalign` change only on such captures. After reset, `ld_valid` and `ld_result` are 0.
- R11: A halfword at an odd offset, a word at a nonzero offset, or size code 2'b11 is misaligned. For a misaligned store, `st_misalign` is 1 and `st_be` and `st_wdata` are 0. For a misaligned load, the captured `ld_misalign` is 1 and `ld_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| endian_big | input | 1 | 1 selects big-endian byte order, 0 little-endian |
| st_size | input | 2 | Store size: 00 byte, 01 halfword, 10 word, 11 reserved |
| st_ofs | input | 2 | Low address bits of the store |
| st_data | input | 32 | Register value to store |
| st_wdata | output | 32 | Memory write word, lane k = byte address base+k |
| st_be | output | 4 | Per-lane write enables |
| st_misalign | output | 1 | Store request is misaligned or of reserved size |
| ld_rvalid | input | 1 | Read data strobe; captures the load this cycle |
| ld_size | input | 2 | Load size, same encoding as st_size |
| ld_ofs | input | 2 | Low address bits of the load |
| ld_signed | input | 1 | 1 sign-extends, 0 zero-extends |
| ld_rdata | input | 32 | Memory read word |
| ld_result | output | 32 | Registered register value |
| ld_valid | output | 1 | ld_result holds a new capture |
| ld_misalign | output | 1 | Captured load was misaligned |

## Verification
On every cycle the assertions check several store and load properties. On the store side they check the lane-enable count for each size, that disabled lanes carry zero, and that a misaligned store enables nothing. On the load side they check the extension pattern above byte and halfword loads, the one-cycle valid timing, and that the result holds between captures. Which register byte lands in which lane, and which lanes assemble a load, can only be shown by the bench's scenarios. The bench compares every size, legal offset, endian mode and extension mode against a byte-array reference, including the fixed AA..DD and 0x04050607 vectors.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;

   // number of bytes moved by an access of the given size
   function automatic int size_bytes(acc_size_e s);
      case (s)
         SZ_BYTE: return 1;
         SZ_HALF: return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/ea_align_check.sv
module ea_align_check
   import ea_pkg::*;
#(
   parameter int LANES = 4,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic [1:0]       size,
   input  logic [OFS_W-1:0] ofs,
   output logic             misalign
);
   always_comb begin
      int nb;
      nb = size_bytes(acc_size_e'(size));
      if (acc_size_e'(size) == SZ_RSVD)
         misalign = 1'b1;
      else
         misalign = (int'(ofs) % nb) != 0;
   end
endmodule

// File: rtl/ea_store_lanes.sv
module ea_store_lanes
   import ea_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic              big,
   input  logic [1:0]        size,
   input  logic [OFS_W-1:0]  ofs,
   input  logic              bad,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  be
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_comb begin
         int nb, rel, src;
         logic hit;
         nb  = size_bytes(acc_size_e'(size));
         rel = k - int'(ofs);
         hit = !bad && (rel >= 0) && (rel < nb);
         src = big ? (nb - 1 - rel) : rel;
         if (!hit) src = 0;
         be[k] = hit;
         wdata[8*k +: 8] = hit ? data[8*src +: 8] : 8'h00;
      end
   end
endmodule

// File: rtl/ea_load_extract.sv
module ea_load_extract
   import ea_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic              big,
   input  logic [1:0]        size,
   input  logic [OFS_W-1:0]  ofs,
   input  logic              sgn,
   input  logic              bad,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] value
);
   logic fill;

   // lane holding the item's most significant byte
   always_comb begin
      int nb, top;
      nb  = size_bytes(acc_size_e'(size));
      top = big ? int'(ofs) : int'(ofs) + nb - 1;
      if (top > LANES - 1) top = 0;
      fill = sgn && rdata[8*top + 7];
   end

   for (genvar j = 0; j < LANES; j++) begin : g_byte
      always_comb begin
         int nb, lane;
         nb   = size_bytes(acc_size_e'(size));
         lane = big ? int'(ofs) + nb - 1 - j : int'(ofs) + j;
         if (lane < 0 || lane > LANES - 1) lane = 0;
         if (bad)
            value[8*j +: 8] = 8'h00;
         else if (j < nb)
            value[8*j +: 8] = rdata[8*lane +: 8];
         else
            value[8*j +: 8] = {8{fill}};
      end
   end
endmodule

// File: rtl/endian_aligner.sv
module endian_aligner
   import ea_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              endian_big,
   input  logic [1:0]        st_size,
   input  logic [OFS_W-1:0]  st_ofs,
   input  logic [DATA_W-1:0] st_data,
   output logic [DATA_W-1:0] st_wdata,
   output logic [LANES-1:0]  st_be,
   output logic              st_misalign,
   input  logic              ld_rvalid,
   input  logic [1:0]        ld_size,
   input  logic [OFS_W-1:0]  ld_ofs,
   input  logic              ld_signed,
   input  logic [DATA_W-1:0] ld_rdata,
   output logic [DATA_W-1:0] ld_result,
   output logic              ld_valid,
   output logic              ld_misalign
);
   if (DATA_W != 32) begin : g_bad_width
      $error("endian_aligner: DATA_W must be 32 (three access sizes up to a word)");
   end

   logic              ld_bad;
   logic [DATA_W-1:0] ld_next;

   ea_align_check #(.LANES(LANES)) u_st_chk (
      .size(st_size), .ofs(st_ofs), .misalign(st_misalign));

   ea_align_check #(.LANES(LANES)) u_ld_chk (
      .size(ld_size), .ofs(ld_ofs), .misalign(ld_bad));

   ea_store_lanes #(.DATA_W(DATA_W)) u_store (
      .big(endian_big), .size(st_size), .ofs(st_ofs), .bad(st_misalign),
      .data(st_data), .wdata(st_wdata), .be(st_be));

   ea_load_extract #(.DATA_W(DATA_W)) u_load (
      .big(endian_big), .size(ld_size), .ofs(ld_ofs), .sgn(ld_signed),
      .bad(ld_bad), .rdata(ld_rdata), .value(ld_next));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_valid    <= 1'b0;
         ld_result   <= '0;
         ld_misalign <= 1'b0;
      end else begin
         ld_valid <= ld_rvalid;
         if (ld_rvalid) begin
            ld_result   <= ld_next;
            ld_misalign <= ld_bad;
         end
      end
   end
endmodule

// File: rtl/ea_checker.sv
module ea_checker
   import ea_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        st_size,
   input logic [DATA_W-1:0] st_wdata,
   input logic [LANES-1:0]  st_be,
   input logic              st_misalign,
   input logic              ld_rvalid,
   input logic [1:0]        ld_size,
   input logic              ld_signed,
   input logic [DATA_W-1:0] ld_result,
   input logic              ld_valid,
   input logic              ld_misalign
);
   logic [DATA_W-1:0] be_mask;
   always_comb
      for (int k = 0; k < LANES; k++) be_mask[8*k +: 8] = {8{st_be[k]}};

   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_misalign && st_size == SZ_BYTE) |-> $countones(st_be) == 1); // R1
   AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_misalign && st_size == SZ_HALF) |-> $countones(st_be) == 2); // R2
   AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_misalign && st_size == SZ_WORD) |-> st_be == '1); // R4
   AST_DEAD_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wdata & ~be_mask) == '0); // R5
   AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rvalid && ld_size == SZ_BYTE && !ld_signed) |=> ld_result[DATA_W-1:8] == '0); // R8
   AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rvalid && ld_size == SZ_HALF && ld_signed)
      |=> ld_result[DATA_W-1:16] == {(DATA_W-16){ld_result[15]}}); // R9
   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_rvalid |=> ld_valid); // R10
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_rvalid |=> !ld_valid); // R10
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_rvalid |=> ($stable(ld_result) && $stable(ld_misalign))); // R10
   AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      st_misalign |-> (st_be == '0 && st_wdata == '0)); // R11
   AST_MISALIGN_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ld_misalign |-> ld_result == '0); // R11
endmodule

bind endian_aligner ea_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .st_size(st_size), .st_wdata(st_wdata),
   .st_be(st_be), .st_misalign(st_misalign), .ld_rvalid(ld_rvalid),
   .ld_size(ld_size), .ld_signed(ld_signed), .ld_result(ld_result),
   .ld_valid(ld_valid), .ld_misalign(ld_misalign));

// File: tb/sim_endian_aligner.sv
module sim_endian_aligner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        endian_big = 1'b0;
   logic [1:0]  st_size = 2'b00;
   logic [1:0]  st_ofs = 2'b00;
   logic [31:0] st_data = '0;
   logic [31:0] st_wdata;
   logic [3:0]  st_be;
   logic        st_misalign;
   logic        ld_rvalid = 1'b0;
   logic [1:0]  ld_size = 2'b00;
   logic [1:0]  ld_ofs = 2'b00;
   logic        ld_signed = 1'b0;
   logic [31:0] ld_rdata = '0;
   logic [31:0] ld_result;
   logic        ld_valid;
   logic        ld_misalign;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] mem [4];
   logic [31:0] exp_res_q [$];
   logic        exp_err_q [$];
   string       exp_tag_q [$];
   logic [31:0] last_res = '0;

   always #10 clk = ~clk;   // 50 MHz

   endian_aligner u0 (.*);

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int nbytes(int sz);
      return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
   endfunction

   function automatic bit is_bad(int sz, int ofs);
      return (sz == 3) || ((ofs % nbytes(sz)) != 0);
   endfunction

   task automatic do_store(bit big, int sz, int ofs, logic [31:0] d);
      logic [31:0] ew;
      logic [3:0]  eb;
      string tag;
      int n;
      @(negedge clk);
      endian_big = big; st_size = 2'(sz); st_ofs = 2'(ofs); st_data = d;
      #1;
      ew = '0; eb = '0; n = nbytes(sz);
      if (is_bad(sz, ofs)) tag = "R11";
      else if (sz == 0) tag = "R1";
      else if (sz == 2) tag = "R4";
      else tag = big ? "R3" : "R2";
      if (!is_bad(sz, ofs)) begin
         for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = big ? d[8*(n-1-i) +: 8] : d[8*i +: 8];
            mem[ofs+i] = b;
            ew[8*(ofs+i) +: 8] = b;
            eb[ofs+i] = 1'b1;
         end
      end
      check({tag, "/R5 store data"}, st_wdata, ew);
      check({tag, " store enables"}, 32'(st_be), 32'(eb));
      check({tag, " store misalign flag"}, 32'(st_misalign), 32'(is_bad(sz, ofs)));
   endtask

   task automatic do_load(bit big, int sz, int ofs, bit sg);
      logic [31:0] v;
      int n;
      string tag;
      @(negedge clk);
      endian_big = big; ld_size = 2'(sz); ld_ofs = 2'(ofs); ld_signed = sg;
      ld_rdata = {mem[3], mem[2], mem[1], mem[0]};
      ld_rvalid = 1'b1;
      v = '0; n = nbytes(sz);
      if (!is_bad(sz, ofs)) begin
         for (int i = 0; i < n; i++)
            v[(big ? 8*(n-1-i) : 8*i) +: 8] = mem[ofs+i];
         if (sg && v[8*n-1])
            for (int b = 8*n; b < 32; b++) v[b] = 1'b1;
      end
      tag = is_bad(sz, ofs) ? "R11" : big ? "R7" : "R6";
      tag = {tag, sg ? "/R9" : "/R8"};
      exp_res_q.push_back(v);
      exp_err_q.push_back(is_bad(sz, ofs));
      exp_tag_q.push_back(tag);
      last_res = v;
   endtask

   task automatic ld_idle();
      @(negedge clk);
      ld_rvalid = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && ld_valid) begin
         if (exp_res_q.size() == 0) begin
            n_tests++; n_fail++;
            $display("FAIL R10: actual unexpected ld_valid expected none");
         end else begin
            logic [31:0] er;
            logic        ee;
            string       et;
            er = exp_res_q.pop_front();
            ee = exp_err_q.pop_front();
            et = exp_tag_q.pop_front();
            check({et, " load result"}, ld_result, er);
            check({et, " load misalign"}, 32'(ld_misalign), 32'(ee));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      check("R10 reset valid", 32'(ld_valid), 0);
      check("R10 reset result", ld_result, 0);
      rst_n = 1'b1;

      // fixed vectors
      do_store(0, 2, 0, 32'h04050607);
      check("R4 little word lanes", st_wdata, 32'h04050607);
      do_store(1, 2, 0, 32'h04050607);
      check("R4 big word lanes", st_wdata, 32'h07060504);
      do_store(1, 1, 0, 32'h04050607);
      check("R3 big half lanes", st_wdata & 32'hFFFF, 32'h0706);
      mem[0] = 8'hAA; mem[1] = 8'hBB; mem[2] = 8'hCC; mem[3] = 8'hDD;
      for (int e = 0; e < 2; e++)
         for (int s = 0; s < 3; s++)
            do_load(e[0], s, 0, 1'b0);
      ld_idle();
      repeat (2) @(negedge clk);

      // sweep: endian x size x legal offset x two data patterns x extension
      for (int e = 0; e < 2; e++)
         for (int s = 0; s < 3; s++)
            for (int o = 0; o < 4; o += nbytes(s))
               for (int p = 0; p < 2; p++) begin
                  do_store(e[0], s, o, p ? 32'hF08C91E3 : 32'h1A2B3C4D);
                  do_load(e[0], s, o, 1'b0);
                  do_load(e[0], s, o, 1'b1);
                  ld_idle();
               end

      // misaligned requests
      do_store(0, 1, 1, 32'hFFFFFFFF);
      do_store(1, 2, 2, 32'hFFFFFFFF);
      do_store(0, 3, 0, 32'hFFFFFFFF);
      do_load(0, 1, 3, 1'b1);
      do_load(1, 2, 1, 1'b0);
      do_load(0, 3, 0, 1'b1);
      ld_idle();

      repeat (3) @(negedge clk);
      check("R10 idle valid low", 32'(ld_valid), 0);
      check("R10 result held", ld_result, last_res);
      check("R10 scoreboard drained", 32'(exp_res_q.size()), 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule